// File: doc/BRIEF.md
# Framed Serial Receive Deserializer

This block turns a one-bit serial data stream into parallel words grouped in frames. One bit is taken per clock. A frame begins when the receive frame-sync line makes an inactive-to-active transition. The frame then carries a programmable number of words, from 1 to 128, with no gap bits between them. The sync comes either from an external pin or from an internal source, and its active level is programmable.

Every qualified sync edge produces a one-cycle event pulse. This detection keeps running while the data path is held in reset, so software can watch for sync activity before it enables reception. Completed words are offered on a single-entry valid/ready port. Two sticky flags record errors: one for words dropped because the port was still full, and one for sync edges that arrived in the middle of a frame.

The control is a two-state machine. In `ST_IDLE` the block waits for a sync edge. The transition *start* (edge seen with `rx_en` high) leads to `ST_SHIFT`, where bits are shifted in. The transition *frame done* (last bit of the last word) returns to `ST_IDLE`. The transition *abort* (`rx_en` low) also returns to `ST_IDLE`, from any cycle.

Top module: `frame_rx_deser`

## Requirements
- R1: `fs_src_sel` = 0 takes the frame sync from `fs_pin`, and 1 takes it from `fs_int`. Activity on the unselected line produces no event and starts no frame.
- R2: `fs_pol` = 0 makes the sync active high, and `fs_pol` = 1 makes it active low.
- R3: Only an inactive-to-active transition of the sync counts as an edge. Holding the sync active for any number of cycles gives no further edges. A sync that is already active when reset is released does not count as an edge.
- R4: `sync_evt` is high for exactly one cycle, in the cycle after the clock edge that detects a sync edge. This holds whether `rx_en` is high or low.
- R5: After a start, bits are sampled MSB first on the following clock edges, one per cycle. Words of `WORD_W` bits follow each other without gaps, and a frame holds `frame_len`+1 words (7-bit field: 0 gives 1 word, 127 gives 128 words). Afterwards the block waits for a new edge.
- R6: `word_valid` goes high right after the clock edge that samples a word's last bit. `word_data` then holds the word. Both stay stable until a cycle with `word_ready` high accepts the word.
- R7: A word that completes while `word_valid` is high and `word_ready` is low is dropped. The stored word is kept and the sticky `overrun` flag is set.
- R8: A sync edge that arrives while a frame is incomplete (in `ST_SHIFT`) is ignored: the frame continues unchanged, and the sticky `fs_err` flag is set.
- R9: With `rx_en` low the data path is held in reset. Any frame in progress is aborted, `word_valid`, `overrun` and `fs_err` are cleared, and no words are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Data path enable; low holds it in reset |
| sd_in | input | 1 | Serial data in |
| fs_pin | input | 1 | External frame sync |
| fs_int | input | 1 | Internally generated frame sync |
| fs_src_sel | input | 1 | Sync source: 0 pin, 1 internal |
| fs_pol | input | 1 | Sync polarity: 0 active high, 1 active low |
| frame_len | input | 7 | Words per frame minus one |
| word_ready | input | 1 | Consumer accepts the offered word |
| word_valid | output | 1 | A received word is offered |
| word_data | output | WORD_W | Received word |
| sync_evt | output | 1 | One-cycle pulse per sync edge |
| overrun | output | 1 | Sticky: a word was dropped |
| fs_err | output | 1 | Sticky: a sync edge arrived mid-frame |

## Verification
The bench changes inputs at the falling edge and reads outputs shortly after it.

A sync level set at falling edge k is detected at the next rising edge, and `sync_evt` is seen at falling edge k+1. The first data bit is driven at that same falling edge. The last bit of word j is driven at falling edge k+(j+1)·WORD_W, and the word shows up on `word_valid` at the falling edge after that. The flags are read at the same point.

A monitor pops a queue of words computed by the bench. It runs at every falling edge, so each word and each event is matched in the cycle it is due. Frame-level counts are compared only after the frame and a trailing window of at least two word times.

// File: rtl/frx_pkg.sv
package frx_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } rx_state_e;
endpackage

// File: rtl/frx_sync_det.sv
module frx_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_pin,
    input  logic fs_int,
    input  logic src_sel,
    input  logic pol,
    output logic edge_o,
    output logic evt_o
);
    logic active;
    logic prev_q;

    // Map the selected line to an active-high level.
    assign active = (src_sel ? fs_int : fs_pin) ^ pol;
    assign edge_o = active & ~prev_q;

    // prev_q resets to 1, so a level already active at reset release is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            evt_o  <= 1'b0;
        end else begin
            prev_q <= active;
            evt_o  <= edge_o;
        end
    end

    // An edge needs an inactive cycle first, so two events can never be adjacent.
    p_evt_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
    p_no_edge_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/frx_shift_fsm.sv
module frx_shift_fsm
    import frx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sd_in,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              sync_edge,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              fs_err
);
    localparam int BIT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    rx_state_e         state_q, state_nx;
    logic [BIT_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  word_cnt;
    logic [WORD_W-2:0] shreg;
    logic              last_bit, last_word;

    assign last_bit  = (bit_cnt == LAST_BIT);
    assign last_word = (word_cnt == frame_len);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state: start, frame done, abort.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (rx_en && sync_edge) state_nx = ST_SHIFT;
            ST_SHIFT: if (!rx_en || (last_bit && last_word)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs: a word is complete when its last bit is being sampled.
    always_comb begin
        push      = (state_q == ST_SHIFT) && rx_en && last_bit;
        push_data = {shreg, sd_in};
    end

    // Data path registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            shreg    <= '0;
            fs_err   <= 1'b0;
        end else if (!rx_en) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            fs_err   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt  <= '0;
                    word_cnt <= '0;
                end
                ST_SHIFT: begin
                    shreg <= push_data[WORD_W-2:0];
                    if (sync_edge) fs_err <= 1'b1;
                    if (last_bit) begin
                        bit_cnt  <= '0;
                        word_cnt <= word_cnt + 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == ST_IDLE));
    p_fserr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_err && rx_en) |=> fs_err);
    p_bitcnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);
    p_start_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_nx == ST_SHIFT) |=> (bit_cnt == '0 && word_cnt == '0));
endmodule

// File: rtl/frx_out_reg.sv
module frx_out_reg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    output logic              overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else if (!rx_en) begin
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else if (push) begin
            if (!valid || ready) begin
                data  <= push_data;
                valid <= 1'b1;
            end else begin
                overrun <= 1'b1;
            end
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && rx_en) |=> (valid && $stable(data)));
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);
endmodule

// File: rtl/frame_rx_deser.sv
module frame_rx_deser #(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sd_in,
    input  logic              fs_pin,
    input  logic              fs_int,
    input  logic              fs_src_sel,
    input  logic              fs_pol,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              word_ready,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              sync_evt,
    output logic              overrun,
    output logic              fs_err
);
    logic              sync_edge;
    logic              push;
    logic [WORD_W-1:0] push_data;

    frx_sync_det u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_pin  (fs_pin),
        .fs_int  (fs_int),
        .src_sel (fs_src_sel),
        .pol     (fs_pol),
        .edge_o  (sync_edge),
        .evt_o   (sync_evt)
    );

    frx_shift_fsm #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .sd_in     (sd_in),
        .frame_len (frame_len),
        .sync_edge (sync_edge),
        .push      (push),
        .push_data (push_data),
        .fs_err    (fs_err)
    );

    frx_out_reg #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .push      (push),
        .push_data (push_data),
        .ready     (word_ready),
        .valid     (word_valid),
        .data      (word_data),
        .overrun   (overrun)
    );

    p_no_word_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !word_valid);
endmodule

// File: tb/frame_rx_deser_tb.sv
module frame_rx_deser_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 8;
    localparam int LEN_W      = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_en = 1'b0;
    logic              sd_in = 1'b0;
    logic              fs_pin = 1'b0;
    logic              fs_int = 1'b0;
    logic              fs_src_sel = 1'b0;
    logic              fs_pol = 1'b0;
    logic [LEN_W-1:0]  frame_len = '0;
    logic              word_ready = 1'b1;
    logic              word_valid;
    logic [WORD_W-1:0] word_data;
    logic              sync_evt;
    logic              overrun;
    logic              fs_err;

    int checks = 0;
    int failures = 0;
    int evt_cnt = 0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] exp_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_rx_deser #(.WORD_W(WORD_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sd_in(sd_in),
        .fs_pin(fs_pin), .fs_int(fs_int), .fs_src_sel(fs_src_sel),
        .fs_pol(fs_pol), .frame_len(frame_len), .word_ready(word_ready),
        .word_valid(word_valid), .word_data(word_data), .sync_evt(sync_evt),
        .overrun(overrun), .fs_err(fs_err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive the selected sync line to the given active state; the other line toggles freely.
    task automatic drive_fs(input bit act);
        if (fs_src_sel) begin
            fs_int = act ^ fs_pol;
            fs_pin = 1'($urandom % 2);
        end else begin
            fs_pin = act ^ fs_pol;
            fs_int = 1'($urandom % 2);
        end
    endtask

    // Monitor: matches words and counts events shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (sync_evt) evt_cnt++;
            if (word_valid && word_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", word_data, 0);
                end else begin
                    exp_w = exp_q.pop_front();
                    check(word_data == exp_w, "R6 word data", word_data, exp_w);
                end
            end
        end
    end

    // n words; only the first 'keep' are expected; glitch>=0 drops sync before that bit.
    task automatic send_frame(input int n, input int keep, input int glitch, input int post);
        logic [WORD_W-1:0] w = '0;
        @(negedge clk); drive_fs(1'b0); sd_in = 1'($urandom % 2);
        @(negedge clk); drive_fs(1'b1);
        for (int b = 0; b < n * WORD_W; b++) begin
            @(negedge clk);
            drive_fs(glitch != b);
            sd_in = 1'($urandom % 2);
            w = {w[WORD_W-2:0], sd_in};
            if ((b % WORD_W) == WORD_W - 1 && (b / WORD_W) < keep) exp_q.push_back(w);
        end
        // Sync held active after the frame: no restart may follow.
        for (int i = 0; i < post; i++) begin
            @(negedge clk); drive_fs(1'b1); sd_in = 1'($urandom % 2);
        end
        @(negedge clk); drive_fs(1'b0);
        @(negedge clk); drive_fs(1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        int n;
        // R3: sync already active through reset release.
        fs_pin = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        check(evt_cnt == 0, "R3 active at reset not an edge", evt_cnt, 0);
        check(word_valid == 1'b0, "R9 reset valid", word_valid, 0);
        check(overrun == 1'b0 && fs_err == 1'b0, "R9 reset flags", {overrun, fs_err}, 0);
        @(negedge clk); fs_pin = 1'b0;
        @(negedge clk);

        // R1: source internal, pin toggles freely, internal held inactive.
        fs_src_sel = 1'b1;
        base = evt_cnt;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); fs_pin = i[0]; fs_int = 1'b0;
        end
        @(negedge clk); @(negedge clk); #2;
        check(evt_cnt == base, "R1 unselected line ignored", evt_cnt - base, 0);
        check(exp_q.size() == 0 && word_valid == 1'b0, "R1 no frame from unselected line", word_valid, 0);

        // R2: active-low on the pin, a single falling transition is one event.
        fs_src_sel = 1'b0; fs_pol = 1'b1; fs_pin = 1'b1;
        rx_en = 1'b0;
        @(negedge clk); base = evt_cnt;
        fs_pin = 1'b0;
        repeat (3) @(negedge clk); #2;
        check(evt_cnt == base + 1, "R2 active-low edge", evt_cnt - base, 1);
        @(negedge clk); fs_pin = 1'b1;
        repeat (3) @(negedge clk); #2;
        check(evt_cnt == base + 1, "R2 return to inactive is no edge", evt_cnt - base, 1);
        rx_en = 1'b1;

        // R5 R6 R1 R2: random frames, source and polarity.
        for (int f = 0; f < 20; f++) begin
            n = 1 + int'($urandom % 4);
            @(negedge clk);
            fs_src_sel = 1'($urandom % 2);
            fs_pol = 1'($urandom % 2);
            drive_fs(1'b0);
            frame_len = LEN_W'(n - 1);
            base = evt_cnt;
            send_frame(n, n, -1, 2 * WORD_W);
            #2;
            check(exp_q.size() == 0, "R5 all words of frame received", exp_q.size(), 0);
            check(evt_cnt == base + 1, "R4 one event per frame R3", evt_cnt - base, 1);
        end

        // R5: longest frame.
        @(negedge clk); fs_src_sel = 1'b0; fs_pol = 1'b0; drive_fs(1'b0);
        frame_len = 7'd127;
        send_frame(128, 128, -1, 2 * WORD_W);
        #2;
        check(exp_q.size() == 0, "R5 128-word frame", exp_q.size(), 0);

        // R8: edge in mid-frame ignored, flag set.
        frame_len = 7'd2;
        base = evt_cnt;
        send_frame(3, 3, 5, 2 * WORD_W);
        #2;
        check(fs_err == 1'b1, "R8 fs_err set", fs_err, 1);
        check(exp_q.size() == 0, "R8 frame continues", exp_q.size(), 0);
        check(evt_cnt == base + 2, "R4 glitch edge also an event", evt_cnt - base, 2);

        // R7: overrun with consumer stalled.
        word_ready = 1'b0;
        frame_len = 7'd1;
        send_frame(2, 1, -1, 2);
        #2;
        check(overrun == 1'b1, "R7 overrun set", overrun, 1);
        check(word_valid == 1'b1, "R7 first word held", word_valid, 1);
        check(word_data == exp_q[0], "R7 held word kept", word_data, exp_q[0]);
        @(negedge clk); word_ready = 1'b1;
        repeat (3) @(negedge clk); #2;
        check(exp_q.size() == 0, "R7 held word delivered", exp_q.size(), 0);
        check(overrun == 1'b1 && fs_err == 1'b1, "R7 R8 flags sticky", {overrun, fs_err}, 3);

        // R9: disable clears flags, and frames are ignored while events continue.
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); @(negedge clk); #2;
        check(overrun == 1'b0 && fs_err == 1'b0, "R9 flags cleared", {overrun, fs_err}, 0);
        base = evt_cnt;
        frame_len = 7'd0;
        send_frame(2, 0, 3, WORD_W);
        #2;
        check(evt_cnt == base + 2, "R4 events while in reset", evt_cnt - base, 2);
        check(word_valid == 1'b0 && fs_err == 1'b0, "R9 no word or flag while off", {word_valid, fs_err}, 0);

        // R9: abort mid-frame, then a clean frame.
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk); drive_fs(1'b1);
        repeat (3) @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk); drive_fs(1'b0); rx_en = 1'b1;
        repeat (2 * WORD_W) @(negedge clk);
        #2;
        check(word_valid == 1'b0, "R9 aborted frame yields no word", word_valid, 0);
        frame_len = 7'd0;
        send_frame(1, 1, -1, WORD_W);
        #2;
        check(exp_q.size() == 0, "R9 receive after abort", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule